// File: doc/BRIEF.md
# Register-access command packet decoder

This block sits between a host byte link and an on-chip register bus. The host sends fixed-length command packets. Each packet asks for a batch of register writes or a batch of register reads. The block takes in a whole packet and replays its entries as single-cycle accesses on the register bus, strictly in packet order. For a read packet it then streams back a fixed-length response that holds, for each entry, the register address, the returned data and the status the bus reported for that access.

A packet starts with an opcode byte and a reserved byte. A list of three-byte entries follows: register address, data, and a spare byte. An address-position byte of 0xFE ends the list, and all bytes after it are padding. With the default of eight entries, a packet is 26 bytes and a response is 24 bytes. Because one packet may name any mix of registers, a host can batch several configuration writes into a single transfer. The same register may appear more than once.

Top module: `regpkt_decoder`

## Requirements
- R1: A packet whose byte 0 is 0x99 is a write packet. Each listed entry produces exactly one write cycle (bus_we high for one clock) with bus_addr equal to the entry's byte 0 and bus_wdata equal to its byte 1. Writes occur on consecutive clocks in packet order, and the first write comes in the clock after the packet's last byte is accepted. A write packet produces no response.
- R2: A packet whose byte 0 is 0xDD is a read packet. Each listed entry produces one read cycle (bus_re high) in packet order, and bus_rdata and bus_status are sampled in that cycle. After the last read, a response is streamed. Response byte 3*i holds entry i's address, byte 3*i+1 holds its read data and byte 3*i+2 holds its status.
- R3: Entry i occupies packet bytes 2+3*i (address), 3+3*i (data) and 4+3*i (spare). An address-position byte of 0xFE ends the list, and every later byte is ignored whatever its value. Packet byte 1 and every spare byte are ignored.
- R4: A packet is always 2+3*MAX_ENTRIES bytes (26 by default). A packet that fills all MAX_ENTRIES entries needs no terminator and produces MAX_ENTRIES accesses.
- R5: A packet with any other value in byte 0 is consumed in full and makes no bus access. It sets bad_cmd_seen, which stays high until reset.
- R6: Response slots beyond the last listed entry carry 0x00 in all three bytes.
- R7: in_ready is low from the clock after a packet's last byte is accepted until its accesses have finished and, for a read packet, until its response has been fully taken. It is high at all other times. No bus access happens while in_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: After reset, in_ready is high, out_valid is low, bus_we and bus_re are low and bad_cmd_seen is low.
- R10: A write packet with no entries makes no access and leaves in_ready high. A read packet with no entries makes no access and returns a response of 3*MAX_ENTRIES zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet byte available |
| in_data | input | 8 | Packet byte |
| in_ready | output | 1 | Block takes a packet byte this clock |
| out_valid | output | 1 | Response byte available |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer takes the response byte this clock |
| bus_addr | output | 8 | Register address of the current access |
| bus_wdata | output | 8 | Write data of the current access |
| bus_we | output | 1 | Write strobe, one clock per write |
| bus_re | output | 1 | Read strobe, one clock per read |
| bus_rdata | input | 8 | Read data, valid in the read-strobe clock |
| bus_status | input | 8 | Per-access status, valid in the strobe clock |
| bad_cmd_seen | output | 1 | Sticky flag: a packet with an unknown opcode arrived |

## Verification
The assertions assume that the register bus answers in the same clock as the strobe. They also assume that the host keeps in_valid and in_data steady between clock edges and that every packet is sent at full length. The bench models a register target whose read data and status are pure functions of the strobed address and of its earlier writes. It changes every input just after a rising edge, so each value is stable across the next edge. It throttles out_ready with a fixed pattern and inserts gaps in in_valid, which exercises the hold rule without breaking any of these assumptions.

// File: rtl/regpkt_pkg.sv
package regpkt_pkg;

  localparam logic [7:0] OP_WRITE   = 8'h99;
  localparam logic [7:0] OP_READ    = 8'hDD;
  localparam logic [7:0] LIST_END   = 8'hFE;
  localparam int         HDR_BYTES  = 2;
  localparam int         SLOT_BYTES = 3;

  typedef enum logic [1:0] {PH_RX, PH_EXEC, PH_RSP} phase_t;
  typedef enum logic [1:0] {KIND_WR, KIND_RD, KIND_BAD} kind_t;

  function automatic kind_t decode_op(input logic [7:0] op);
    if (op == OP_WRITE) return KIND_WR;
    if (op == OP_READ)  return KIND_RD;
    return KIND_BAD;
  endfunction

  // entry number that a body offset falls into
  function automatic int unsigned slot_of(input int unsigned off);
    return off / SLOT_BYTES;
  endfunction

  // position inside a three-byte slot: 0 address, 1 data, 2 spare/status
  function automatic int unsigned lane_of(input int unsigned off);
    return off % SLOT_BYTES;
  endfunction

endpackage

// File: rtl/regpkt_parser.sv
module regpkt_parser
  import regpkt_pkg::*;
#(
  parameter int MAX_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int NUM_W       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic [7:0]                   byte_in,
  output logic                         pkt_start,
  output logic                         pkt_done,
  output kind_t                        kind,
  output logic [NUM_W-1:0]             n_entries,
  output logic [MAX_ENTRIES-1:0][7:0]  entry_addr,
  output logic [MAX_ENTRIES-1:0][7:0]  entry_data
);

  localparam int PKT_BYTES = HDR_BYTES + SLOT_BYTES * MAX_ENTRIES;
  localparam int POS_W     = $clog2(PKT_BYTES);

  logic [POS_W-1:0]            pos_q;
  logic [7:0]                  op_q;
  logic                        ended_q;
  logic [NUM_W-1:0]            n_q;
  logic [MAX_ENTRIES-1:0][7:0] addr_q;
  logic [MAX_ENTRIES-1:0][7:0] data_q;

  logic [POS_W-1:0] off;
  logic [IDX_W-1:0] slot;
  logic [1:0]       lane;
  logic             in_body;
  logic             at_last;

  always_comb begin
    in_body = pos_q >= POS_W'(HDR_BYTES);
    off     = pos_q - POS_W'(HDR_BYTES);
    slot    = IDX_W'(slot_of(32'(off)));
    lane    = 2'(lane_of(32'(off)));
    at_last = pos_q == POS_W'(PKT_BYTES - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      op_q    <= '0;
      ended_q <= 1'b0;
      n_q     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (take) begin
      pos_q <= at_last ? '0 : pos_q + POS_W'(1);
      if (pos_q == '0) begin
        op_q    <= byte_in;
        ended_q <= 1'b0;
        n_q     <= '0;
      end else if (in_body && !ended_q) begin
        if (lane == 2'd0) begin
          if (byte_in == LIST_END) begin
            ended_q <= 1'b1;
          end else begin
            addr_q[slot] <= byte_in;
            n_q          <= n_q + NUM_W'(1);
          end
        end else if (lane == 2'd1) begin
          data_q[slot] <= byte_in;
        end
      end
    end
  end

  assign pkt_start  = take && (pos_q == '0);
  assign pkt_done   = take && at_last;
  assign kind       = decode_op(op_q);
  assign n_entries  = n_q;
  assign entry_addr = addr_q;
  assign entry_data = data_q;

  // R3: once the list has ended, later bytes of the packet never add entries
  assert_end_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ended_q && pos_q != '0) |=> $stable(n_q));

endmodule

// File: rtl/regpkt_exec.sv
module regpkt_exec
  import regpkt_pkg::*;
#(
  parameter int MAX_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int NUM_W       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         run,
  input  logic                         is_rd,
  input  logic [NUM_W-1:0]             n_entries,
  input  logic [MAX_ENTRIES-1:0][7:0]  entry_addr,
  input  logic [MAX_ENTRIES-1:0][7:0]  entry_data,
  input  logic [7:0]                   bus_rdata,
  input  logic [7:0]                   bus_status,
  output logic [7:0]                   bus_addr,
  output logic [7:0]                   bus_wdata,
  output logic                         bus_we,
  output logic                         bus_re,
  output logic                         acc_last,
  output logic [MAX_ENTRIES-1:0][7:0]  res_addr,
  output logic [MAX_ENTRIES-1:0][7:0]  res_data,
  output logic [MAX_ENTRIES-1:0][7:0]  res_stat
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) idx_q <= '0;
    else                idx_q <= idx_q + IDX_W'(1);
  end

  assign bus_addr  = entry_addr[idx_q];
  assign bus_wdata = entry_data[idx_q];
  assign bus_we    = run && !is_rd;
  assign bus_re    = run && is_rd;
  assign acc_last  = run && (NUM_W'(idx_q) + NUM_W'(1) == n_entries);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      res_addr <= '0;
      res_data <= '0;
      res_stat <= '0;
    end else if (bus_re) begin
      res_addr[idx_q] <= entry_addr[idx_q];
      res_data[idx_q] <= bus_rdata;
      res_stat[idx_q] <= bus_status;
    end
  end

  // R1: accesses walk the list one entry per clock without gaps
  assert_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && idx_q != '0) |-> ($past(run) && ($past(idx_q) + IDX_W'(1) == idx_q)));

  // R3: no access beyond the last listed entry
  assert_within_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (NUM_W'(idx_q) < n_entries));

endmodule

// File: rtl/regpkt_resp.sv
module regpkt_resp
  import regpkt_pkg::*;
#(
  parameter int MAX_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         out_ready,
  input  logic [MAX_ENTRIES-1:0][7:0]  res_addr,
  input  logic [MAX_ENTRIES-1:0][7:0]  res_data,
  input  logic [MAX_ENTRIES-1:0][7:0]  res_stat,
  output logic                         out_valid,
  output logic [7:0]                   out_data,
  output logic                         rsp_last
);

  localparam int RSP_BYTES = SLOT_BYTES * MAX_ENTRIES;
  localparam int PTR_W     = $clog2(RSP_BYTES);

  logic [PTR_W-1:0] ptr_q;
  logic [IDX_W-1:0] slot;
  logic [1:0]       lane;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) ptr_q <= '0;
    else if (out_ready) ptr_q <= ptr_q + PTR_W'(1);
  end

  always_comb begin
    slot = IDX_W'(slot_of(32'(ptr_q)));
    lane = 2'(lane_of(32'(ptr_q)));
    case (lane)
      2'd0:    out_data = res_addr[slot];
      2'd1:    out_data = res_data[slot];
      default: out_data = res_stat[slot];
    endcase
  end

  assign out_valid = run;
  assign rsp_last  = run && out_ready && (ptr_q == PTR_W'(RSP_BYTES - 1));

  // R8: a stalled response byte is held
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/regpkt_decoder.sv
module regpkt_decoder
  import regpkt_pkg::*;
#(
  parameter int MAX_ENTRIES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic [7:0] bus_addr,
  output logic [7:0] bus_wdata,
  output logic       bus_we,
  output logic       bus_re,
  input  logic [7:0] bus_rdata,
  input  logic [7:0] bus_status,
  output logic       bad_cmd_seen
);

  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
  localparam int NUM_W = $clog2(MAX_ENTRIES + 1);

  phase_t phase_q;
  logic   err_q;

  logic                        take;
  logic                        pkt_start;
  logic                        pkt_done;
  kind_t                       kind;
  logic                        is_rd;
  logic [NUM_W-1:0]            n_entries;
  logic [MAX_ENTRIES-1:0][7:0] entry_addr;
  logic [MAX_ENTRIES-1:0][7:0] entry_data;
  logic                        acc_last;
  logic                        rsp_last;
  logic [MAX_ENTRIES-1:0][7:0] res_addr;
  logic [MAX_ENTRIES-1:0][7:0] res_data;
  logic [MAX_ENTRIES-1:0][7:0] res_stat;

  assign in_ready     = (phase_q == PH_RX);
  assign take         = in_ready && in_valid;
  assign is_rd        = (kind == KIND_RD);
  assign bad_cmd_seen = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_RX;
      err_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_RX: if (pkt_done) begin
          case (kind)
            KIND_WR: phase_q <= (n_entries != '0) ? PH_EXEC : PH_RX;
            KIND_RD: phase_q <= (n_entries != '0) ? PH_EXEC : PH_RSP;
            default: err_q   <= 1'b1;
          endcase
        end
        PH_EXEC: if (acc_last) phase_q <= is_rd ? PH_RSP : PH_RX;
        PH_RSP:  if (rsp_last) phase_q <= PH_RX;
        default: phase_q <= PH_RX;
      endcase
    end
  end

  regpkt_parser #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W), .NUM_W(NUM_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_data),
    .pkt_start(pkt_start), .pkt_done(pkt_done), .kind(kind),
    .n_entries(n_entries), .entry_addr(entry_addr), .entry_data(entry_data)
  );

  regpkt_exec #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W), .NUM_W(NUM_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .clear(pkt_start), .run(phase_q == PH_EXEC),
    .is_rd(is_rd), .n_entries(n_entries), .entry_addr(entry_addr),
    .entry_data(entry_data), .bus_rdata(bus_rdata), .bus_status(bus_status),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .acc_last(acc_last), .res_addr(res_addr), .res_data(res_data), .res_stat(res_stat)
  );

  regpkt_resp #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .run(phase_q == PH_RSP), .out_ready(out_ready),
    .res_addr(res_addr), .res_data(res_data), .res_stat(res_stat),
    .out_valid(out_valid), .out_data(out_data), .rsp_last(rsp_last)
  );

  // R7: the input side is closed while the bus is in use
  assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) |-> !in_ready);

  // R5: the unknown-opcode flag never clears on its own
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd_seen |=> bad_cmd_seen);

  // R5: an unknown opcode is followed by no access
  assert_bad_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && kind == KIND_BAD) |=> !(bus_we || bus_re));

  // R2: responses are produced for read packets only
  assert_rsp_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> is_rd);

endmodule

// File: tb/sim_regpkt_decoder.sv
`timescale 1ns/1ps
module sim_regpkt_decoder;

  localparam int NE   = 8;
  localparam int PKT  = 2 + 3 * NE;
  localparam int RSPN = 3 * NE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, bus_status;
  logic       bus_we, bus_re, bad_cmd_seen;

  always #4 clk = ~clk;

  regpkt_decoder #(.MAX_ENTRIES(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_status(bus_status), .bad_cmd_seen(bad_cmd_seen)
  );

  function automatic logic [7:0] dev_init(input int a);
    return 8'((a * 5 + 3) & 255);
  endfunction
  function automatic logic [7:0] dev_stat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  // register target seen by the block
  logic [7:0] dev_mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dev_mem[i] <= dev_init(i);
    end else if (bus_we) begin
      dev_mem[bus_addr] <= bus_wdata;
    end
  end
  assign bus_rdata  = dev_mem[bus_addr];
  assign bus_status = dev_stat(bus_addr);

  int nchk = 0;
  int nfail = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] mreg [256];
  logic [7:0] pk_q [$];
  bit         aq_we [$];
  logic [7:0] aq_addr [$];
  logic [7:0] aq_data [$];
  logic [7:0] rd_a [$];
  logic [7:0] rd_d [$];
  logic [7:0] rd_s [$];
  logic [7:0] rq [$];
  bit         rq_pad [$];
  bit         m_err = 1'b0;
  bit         m_held = 1'b0;
  int         cycles = 0;
  int         acc_cnt = 0;
  int         ohs_cnt = 0;
  bit         bp_mode = 1'b0;
  int         bp_cyc = 0;

  task automatic build_rsp();
    for (int i = 0; i < NE; i++) begin
      if (i < rd_a.size()) begin
        rq.push_back(rd_a[i]); rq.push_back(rd_d[i]); rq.push_back(rd_s[i]);
        rq_pad.push_back(1'b0); rq_pad.push_back(1'b0); rq_pad.push_back(1'b0);
      end else begin
        for (int k = 0; k < 3; k++) begin rq.push_back(8'h00); rq_pad.push_back(1'b1); end
      end
    end
    rd_a.delete(); rd_d.delete(); rd_s.delete();
  endtask

  task automatic take_packet();
    logic [7:0] ea [$];
    logic [7:0] ed [$];
    bit ended = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (!ended) begin
        if (pk_q[2 + 3 * i] == 8'hFE) ended = 1'b1;
        else begin ea.push_back(pk_q[2 + 3 * i]); ed.push_back(pk_q[3 + 3 * i]); end
      end
    end
    if (pk_q[0] == 8'h99 || pk_q[0] == 8'hDD) begin
      for (int i = 0; i < ea.size(); i++) begin
        aq_we.push_back(pk_q[0] == 8'h99); aq_addr.push_back(ea[i]); aq_data.push_back(ed[i]);
      end
      if (pk_q[0] == 8'hDD && ea.size() == 0) build_rsp();
    end else begin
      m_err = 1'b1;
    end
    pk_q.delete();
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mreg[i] = dev_init(i);
      pk_q.delete(); aq_we.delete(); aq_addr.delete(); aq_data.delete();
      rq.delete(); rq_pad.delete(); m_err = 1'b0; m_held = 1'b0;
    end else begin
      bit had_acc, had_rsp, rx_open, a_we;
      logic [7:0] a_addr, a_data;
      string tag;
      cycles++;
      if (cycles > 100000) begin
        nfail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
      end
      if (bus_we || bus_re) acc_cnt++;
      if (out_valid && out_ready) ohs_cnt++;
      had_acc = aq_we.size() > 0;
      had_rsp = rq.size() > 0;
      rx_open = !had_acc && !had_rsp;
      // compare against the model
      check(in_ready === rx_open, "R7", "in_ready", int'(in_ready), int'(rx_open));
      check(bad_cmd_seen === m_err, "R5", "bad_cmd_seen", int'(bad_cmd_seen), int'(m_err));
      if (had_acc) begin
        tag = aq_we[0] ? "R1" : "R2";
        check(bus_we === aq_we[0] && bus_re === !aq_we[0], tag, "strobes",
              int'({bus_we, bus_re}), int'({aq_we[0], !aq_we[0]}));
        check(bus_addr === aq_addr[0], tag, "bus_addr", int'(bus_addr), int'(aq_addr[0]));
        if (aq_we[0])
          check(bus_wdata === aq_data[0], "R1", "bus_wdata", int'(bus_wdata), int'(aq_data[0]));
      end else begin
        check(!bus_we && !bus_re, "R7", "idle strobes", int'({bus_we, bus_re}), 0);
      end
      check(out_valid === had_rsp, "R2", "out_valid", int'(out_valid), int'(had_rsp));
      if (had_rsp) begin
        tag = m_held ? "R8" : (rq_pad[0] ? "R6" : "R2");
        check(out_data === rq[0], tag, "out_data", int'(out_data), int'(rq[0]));
      end
      // advance the model to the next edge
      m_held = had_rsp && !out_ready;
      if (had_rsp && out_ready) begin void'(rq.pop_front()); void'(rq_pad.pop_front()); end
      if (had_acc) begin
        a_we = aq_we.pop_front(); a_addr = aq_addr.pop_front(); a_data = aq_data.pop_front();
        if (a_we) mreg[a_addr] = a_data;
        else begin
          rd_a.push_back(a_addr); rd_d.push_back(mreg[a_addr]); rd_s.push_back(dev_stat(a_addr));
          if (aq_we.size() == 0) build_rsp();
        end
      end
      if (rx_open && in_valid) begin
        pk_q.push_back(in_data);
        if (pk_q.size() == PKT) take_packet();
      end
    end
  end

  // response throttling pattern
  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? (bp_cyc % 3 != 1) : 1'b1;
    bp_cyc++;
  end

  // ---------------- stimulus ----------------
  logic [7:0] pk_buf [PKT];
  bit gap_mode = 1'b0;

  task automatic mk_pkt(input logic [7:0] op);
    for (int i = 0; i < PKT; i++) pk_buf[i] = 8'hFE;
    pk_buf[0] = op;
    pk_buf[1] = 8'h00;
  endtask

  task automatic add_ent(input int i, input logic [7:0] a, input logic [7:0] d);
    pk_buf[2 + 3 * i] = a;
    pk_buf[3 + 3 * i] = d;
    pk_buf[4 + 3 * i] = 8'h00;
  endtask

  task automatic put_byte(input logic [7:0] b);
    while (!in_ready) begin @(posedge clk); #1; end
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_pkt();
    for (int i = 0; i < PKT; i++) begin
      put_byte(pk_buf[i]);
      if (gap_mode && (i % 5 == 3)) begin @(posedge clk); #1; end
    end
    repeat (3) @(posedge clk);
    while (!(in_ready && !out_valid)) @(posedge clk);
    #1;
  endtask

  int a0, o0;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R9: reset state
    check(in_ready === 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    check(!bus_we && !bus_re, "R9", "strobes after reset", int'({bus_we, bus_re}), 0);
    check(bad_cmd_seen === 1'b0, "R9", "flag after reset", int'(bad_cmd_seen), 0);
    @(posedge clk); #1;

    // R1: mixed configuration writes, same register twice
    a0 = acc_cnt;
    mk_pkt(8'h99);
    add_ent(0, 8'h30, 8'h80); add_ent(1, 8'h30, 8'h81);
    add_ent(2, 8'h14, 8'hFF); add_ent(3, 8'h24, 8'hF7);
    send_pkt();
    check(acc_cnt - a0 == 4, "R1", "write count", acc_cnt - a0, 4);
    check(dev_mem[8'h30] === 8'h81, "R1", "last write wins", int'(dev_mem[8'h30]), 8'h81);

    // R2 / R6: read back three registers, rest of response zero
    a0 = acc_cnt; o0 = ohs_cnt;
    mk_pkt(8'hDD);
    add_ent(0, 8'h30, 8'h00); add_ent(1, 8'h14, 8'h00); add_ent(2, 8'h24, 8'h00);
    send_pkt();
    check(acc_cnt - a0 == 3, "R2", "read count", acc_cnt - a0, 3);
    check(ohs_cnt - o0 == RSPN, "R2", "response length", ohs_cnt - o0, RSPN);

    // R3: terminator, then non-padding garbage; reserved and spare bytes ignored
    a0 = acc_cnt;
    mk_pkt(8'h99);
    pk_buf[1] = 8'h55;
    add_ent(0, 8'h40, 8'h11); pk_buf[4] = 8'h77;
    add_ent(1, 8'h41, 8'h22);
    pk_buf[8] = 8'hFE; pk_buf[9] = 8'h42; pk_buf[10] = 8'h33; pk_buf[11] = 8'h43;
    send_pkt();
    check(acc_cnt - a0 == 2, "R3", "accesses before terminator", acc_cnt - a0, 2);
    check(dev_mem[8'h42] === dev_init(8'h42), "R3", "byte after terminator",
          int'(dev_mem[8'h42]), int'(dev_init(8'h42)));

    // R4: full packet of writes, then full read under backpressure and input gaps
    a0 = acc_cnt;
    mk_pkt(8'h99);
    for (int i = 0; i < NE; i++) add_ent(i, 8'(8'h60 + i), 8'(8'hA0 + i));
    send_pkt();
    check(acc_cnt - a0 == NE, "R4", "full write count", acc_cnt - a0, NE);
    bp_mode = 1'b1; gap_mode = 1'b1;
    a0 = acc_cnt; o0 = ohs_cnt;
    mk_pkt(8'hDD);
    for (int i = 0; i < NE; i++) add_ent(i, 8'(8'h67 - i), 8'h00);
    send_pkt();
    check(acc_cnt - a0 == NE, "R4", "full read count", acc_cnt - a0, NE);
    check(ohs_cnt - o0 == RSPN, "R8", "stalled response length", ohs_cnt - o0, RSPN);
    bp_mode = 1'b0; gap_mode = 1'b0;

    // R5: unknown opcode
    a0 = acc_cnt;
    mk_pkt(8'h42);
    add_ent(0, 8'h50, 8'h99);
    send_pkt();
    check(acc_cnt - a0 == 0, "R5", "no access on bad opcode", acc_cnt - a0, 0);
    check(bad_cmd_seen === 1'b1, "R5", "flag set", int'(bad_cmd_seen), 1);
    check(dev_mem[8'h50] === dev_init(8'h50), "R5", "target untouched",
          int'(dev_mem[8'h50]), int'(dev_init(8'h50)));
    mk_pkt(8'h99);
    add_ent(0, 8'h51, 8'h3C);
    send_pkt();
    check(bad_cmd_seen === 1'b1, "R5", "flag stays set", int'(bad_cmd_seen), 1);

    // R10: empty packets
    a0 = acc_cnt;
    mk_pkt(8'h99);
    send_pkt();
    check(acc_cnt - a0 == 0, "R10", "empty write", acc_cnt - a0, 0);
    a0 = acc_cnt; o0 = ohs_cnt;
    bp_mode = 1'b1;
    mk_pkt(8'hDD);
    send_pkt();
    bp_mode = 1'b0;
    check(acc_cnt - a0 == 0, "R10", "empty read accesses", acc_cnt - a0, 0);
    check(ohs_cnt - o0 == RSPN, "R10", "empty read response length", ohs_cnt - o0, RSPN);

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule